// File: doc/BRIEF.md
# Serial Register Command Slave

This block is the command port of a decoder: an external host reaches a bank of sixteen 16-bit control registers over a four-wire serial link. Each command frame is exactly 32 serial clocks long: one opcode byte, one address byte and one 16-bit data word. Every field is sent most significant bit first. The host drives input data that the block samples on rising serial clock edges. For reads, the block returns the register value on the serial output, changing it on falling edges.

All serial inputs are resynchronised into the system clock. The system clock must run at least four times faster than the serial clock, and the bench uses a ratio of sixteen. The register bank itself lies outside the block and is reached through a single-cycle write and read strobe port. The time the decoder needs to act on a command is modelled as a programmable busy period. During that period the ready flag stays low and further frames are discarded. An access record output reports the last accepted address and whether that access was a write.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `dreq` is high, `so_oe` is low, `acc_status` is zero and neither register strobe is active.
- R2: A frame with opcode 0x02 (bits 31:24) produces exactly one `reg_wr_en` pulse once all 32 bits have arrived. `reg_addr` is taken from bits 3:0 of the address byte (frame bits 23:16) and `reg_wdata` from frame bits 15:0.
- R3: A frame with opcode 0x03 produces one `reg_rd_en` pulse after the 16th bit. The returned value is driven on `so` MSb first: bit 15 is valid before the 17th rising serial edge, and the next bit follows each later falling edge. `so_oe` is high during this data phase.
- R4: A frame with any opcode other than 0x02 or 0x03 has no effect: no strobe, no busy period and no change to `acc_status`.
- R5: Raising `cs_n` before the 32nd bit abandons the frame with no strobe and no busy period. After `cs_n` goes high, `so_oe` returns low. The first rising edge after `cs_n` falls again carries bit 31 of a new frame.
- R6: When a read or write frame is accepted, `dreq` goes low for exactly `exec_len` system clock cycles, counted from the value `exec_len` holds when the last bit arrives. A value of 0 counts as 1.
- R7: A frame that reaches its last bit while `dreq` is low is discarded, and so is a read whose address arrives while `dreq` is low. Neither produces a strobe, a status change or an extension of the busy period.
- R8: Each accepted frame loads `acc_status` with the register address in bits 3:0. Bit 4 is set for a write and clear for a read.
- R9: During the data phase of a read, `si` is ignored. The result, the strobes and the status do not depend on the data bits sent.
- R10: `so_oe` stays low throughout a write frame.
- R11: Serial bits beyond the 32nd, sent before `cs_n` rises, are ignored.
- R12: A read or write whose address byte has any of bits 7:4 set is ignored in the same way as an unknown opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select; high aborts and idles the link |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| reg_wr_en | output | 1 | Register write strobe, one cycle |
| reg_rd_en | output | 1 | Register read strobe, one cycle |
| reg_addr | output | 4 | Register index for the active strobe |
| reg_wdata | output | 16 | Write data for `reg_wr_en` |
| reg_rdata | input | 16 | Register value, valid in the `reg_rd_en` cycle |
| exec_len | input | 16 | Busy duration for the command being accepted |
| dreq | output | 1 | Ready for a new command when high |
| acc_status | output | 5 | Last accepted access: write flag (bit 4) and address (bits 3:0) |

## Verification
Two mechanisms can act in the same window: the busy countdown from an accepted command, and the completion of a following frame. The bench provokes this by loading a 2000-cycle busy period and then sending a second write, and a read, without waiting for `dreq`. Correct behaviour is judged at the ports. No second write strobe may appear and no read strobe may appear. `acc_status` must keep the first command's value, and `dreq` must stay low for exactly the first command's 2000 cycles, with no restart.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam int         OP_W     = 8;
    localparam int         ADDR_W   = 8;
    localparam int         HDR_W    = OP_W + ADDR_W;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
            else        chain_q <= {chain_q[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_busy_timer.sv
module spi_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = (len == '0) ? CNT_W'(1) : len;
        else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int REG_AW = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  exec_len,
    output logic              dreq,
    output logic [REG_AW:0]   acc_status
);
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_BW  = $clog2(FRAME_W + 1);
    localparam logic [CNT_BW-1:0] LAST_HDR = CNT_BW'(HDR_W - 1);
    localparam logic [CNT_BW-1:0] HDR_DONE = CNT_BW'(HDR_W);
    localparam logic [CNT_BW-1:0] LAST_BIT = CNT_BW'(FRAME_W - 1);
    localparam logic [CNT_BW-1:0] FULL     = CNT_BW'(FRAME_W);

    typedef struct packed {
        logic [CNT_BW-1:0]  cnt;
        logic [FRAME_W-2:0] in_sh;
        logic [DATA_W-1:0]  out_sh;
        logic               rd_act;
        logic               so;
        logic               so_oe;
        logic [REG_AW:0]    stat;
        logic               sck_q;
    } state_t;

    state_t s_d, s_q;
    logic   cs_s, sck_s, si_s;
    logic   busy, start;

    spi_in_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, si}),
        .dout ({cs_s, sck_s, si_s})
    );

    spi_busy_timer #(.CNT_W(CNT_W)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .len  (exec_len),
        .busy (busy)
    );

    always_comb begin
        logic               rise, fall;
        logic [FRAME_W-1:0] nxt;
        logic [7:0]         hdr_op, hdr_adr, cmd_op, cmd_adr;
        s_d       = s_q;
        reg_wr_en = 1'b0;
        reg_rd_en = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        start     = 1'b0;
        rise      = sck_s & ~s_q.sck_q;
        fall      = ~sck_s & s_q.sck_q;
        s_d.sck_q = sck_s;
        nxt       = {s_q.in_sh, si_s};
        hdr_op    = nxt[HDR_W-1 -: OP_W];
        hdr_adr   = nxt[ADDR_W-1:0];
        cmd_op    = nxt[FRAME_W-1 -: OP_W];
        cmd_adr   = nxt[DATA_W+ADDR_W-1 -: ADDR_W];

        if (cs_s) begin
            s_d.cnt    = '0;
            s_d.rd_act = 1'b0;
            s_d.so_oe  = 1'b0;
        end else begin
            if (rise && s_q.cnt < FULL) begin
                s_d.in_sh = nxt[FRAME_W-2:0];
                s_d.cnt   = s_q.cnt + CNT_BW'(1);
                if (s_q.cnt == LAST_HDR && hdr_op == OP_READ && !busy
                    && (hdr_adr >> REG_AW) == 8'd0) begin
                    reg_rd_en  = 1'b1;
                    reg_addr   = hdr_adr[REG_AW-1:0];
                    s_d.out_sh = reg_rdata;
                    s_d.rd_act = 1'b1;
                end
                if (s_q.cnt == LAST_BIT && !busy && (cmd_adr >> REG_AW) == 8'd0) begin
                    if (cmd_op == OP_WRITE) begin
                        reg_wr_en = 1'b1;
                        reg_addr  = cmd_adr[REG_AW-1:0];
                        reg_wdata = nxt[DATA_W-1:0];
                    end
                    if (cmd_op == OP_WRITE || (cmd_op == OP_READ && s_q.rd_act)) begin
                        start    = 1'b1;
                        s_d.stat = {cmd_op == OP_WRITE, cmd_adr[REG_AW-1:0]};
                    end
                end
            end
            if (fall && s_q.rd_act && s_q.cnt >= HDR_DONE && s_q.cnt < FULL) begin
                s_d.so     = s_q.out_sh[DATA_W-1];
                s_d.out_sh = {s_q.out_sh[DATA_W-2:0], 1'b0};
                s_d.so_oe  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sck_q: 1'b0, default: '0};
        else        s_q <= s_d;
    end

    assign so         = s_q.so;
    assign so_oe      = s_q.so_oe;
    assign dreq       = ~busy;
    assign acc_status = s_q.stat;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
    parameter int REG_AW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr_en,
    input logic            reg_rd_en,
    input logic            dreq,
    input logic [REG_AW:0] acc_status
);
    // R2 R3: a frame never strobes both ways in one cycle
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en}));
    // R7: no write is issued while busy
    a_r7_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> dreq);
    // R7: no read is issued while busy
    a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> dreq);
    // R6: an accepted write is followed by a busy period
    a_r6_busy_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !dreq);
    // R8: the access record only changes as a busy period begins
    a_r8_status_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_status) |-> !dreq);
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .dreq      (dreq),
    .acc_status(acc_status)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic        so, so_oe, reg_wr_en, reg_rd_en, dreq;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [15:0] exec_len = 16'd10;
    logic [4:0]  acc_status;

    logic [15:0] model [16];
    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0, low_cnt = 0;
    logic [3:0]  last_wa;
    logic [15:0] last_wd;
    logic        oe_seen = 1'b0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .exec_len(exec_len), .dreq(dreq), .acc_status(acc_status)
    );

    assign reg_rdata = model[reg_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            model[reg_addr] <= reg_wdata;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= reg_addr;
            last_wd <= reg_wdata;
        end
        if (reg_rd_en) rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst_n && !dreq) low_cnt <= low_cnt + 1;
        if (so_oe) oe_seen <= 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk);
        low_cnt = 0;
        oe_seen = 1'b0;
    endtask

    // nbits rising edges; bit i uses frame[31 - (i % 32)]
    task automatic xfer(input logic [31:0] frame, input int nbits, output logic [15:0] rd);
        rd = '0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            si = frame[31 - (i % 32)];
            repeat (H) @(negedge clk);
            if (i >= 16 && i < 32) rd[31 - i] = so;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000 && !dreq; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(dreq == 1'b1, "R1 dreq", dreq, 1);
        chk(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
        chk(acc_status == 5'd0, "R1 status", acc_status, 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R1 strobes", wr_cnt + rd_cnt, 0);
    endtask

    task automatic t_write();
        logic [15:0] rd;
        int w0 = wr_cnt;
        exec_len = 16'd20;
        clr_mon();
        xfer({8'h02, 8'h05, 16'hA5C3}, 32, rd);
        wait_ready();
        chk(wr_cnt == w0 + 1, "R2 write count", wr_cnt, w0 + 1);
        chk(last_wa == 4'h5, "R2 write addr", last_wa, 5);
        chk(last_wd == 16'hA5C3, "R2 write data", last_wd, 16'hA5C3);
        chk(low_cnt == 20, "R6 busy length", low_cnt, 20);
        chk(acc_status == 5'h15, "R8 write status", acc_status, 5'h15);
        chk(oe_seen == 1'b0, "R10 so_oe in write", oe_seen, 0);
    endtask

    task automatic t_read();
        logic [15:0] rd;
        int w0, r0;
        exec_len = 16'd3;
        xfer({8'h02, 8'h09, 16'h3C96}, 32, rd);
        wait_ready();
        w0 = wr_cnt; r0 = rd_cnt;
        clr_mon();
        xfer({8'h03, 8'h09, 16'hFFFF}, 32, rd);
        wait_ready();
        chk(rd == 16'h3C96, "R3 read data", rd, 16'h3C96);
        chk(rd_cnt == r0 + 1, "R3 read strobe", rd_cnt, r0 + 1);
        chk(oe_seen == 1'b1, "R3 so_oe", oe_seen, 1);
        chk(so_oe == 1'b0, "R5 so_oe after cs high", so_oe, 0);
        chk(wr_cnt == w0, "R9 no write from read", wr_cnt, w0);
        chk(acc_status == 5'h09, "R8 read status", acc_status, 5'h09);
        xfer({8'h03, 8'h09, 16'h0000}, 32, rd);
        wait_ready();
        chk(rd == 16'h3C96, "R9 si ignored in read", rd, 16'h3C96);
        chk(low_cnt == 6, "R6 read busy", low_cnt, 6);
    endtask

    task automatic t_badop();
        logic [15:0] rd;
        int w0 = wr_cnt, r0 = rd_cnt;
        logic [4:0] st = acc_status;
        clr_mon();
        xfer({8'h07, 8'h02, 16'h1234}, 32, rd);
        xfer({8'h82, 8'h02, 16'h1234}, 32, rd);
        chk(wr_cnt == w0 && rd_cnt == r0, "R4 no strobe", wr_cnt + rd_cnt, w0 + r0);
        chk(low_cnt == 0, "R4 no busy", low_cnt, 0);
        chk(acc_status == st, "R4 status kept", acc_status, st);
    endtask

    task automatic t_badaddr();
        logic [15:0] rd;
        int w0 = wr_cnt, r0 = rd_cnt;
        clr_mon();
        xfer({8'h02, 8'h12, 16'h5555}, 32, rd);
        xfer({8'h03, 8'h80, 16'h0000}, 32, rd);
        chk(wr_cnt == w0 && rd_cnt == r0, "R12 high address ignored", wr_cnt + rd_cnt, w0 + r0);
        chk(low_cnt == 0, "R12 no busy", low_cnt, 0);
    endtask

    task automatic t_abort();
        logic [15:0] rd;
        int w0 = wr_cnt;
        exec_len = 16'd5;
        clr_mon();
        xfer({8'h02, 8'h0A, 16'hFFFF}, 20, rd);
        chk(wr_cnt == w0 && low_cnt == 0, "R5 aborted frame", wr_cnt, w0);
        xfer({8'h02, 8'h03, 16'h0F0F}, 32, rd);
        wait_ready();
        chk(wr_cnt == w0 + 1 && last_wa == 4'h3, "R5 resync addr", last_wa, 3);
        chk(last_wd == 16'h0F0F, "R5 resync data", last_wd, 16'h0F0F);
    endtask

    task automatic t_busy_zero();
        logic [15:0] rd;
        exec_len = 16'd0;
        clr_mon();
        xfer({8'h02, 8'h04, 16'h0001}, 32, rd);
        wait_ready();
        chk(low_cnt == 1, "R6 zero length", low_cnt, 1);
    endtask

    task automatic t_busy_drop();
        logic [15:0] rd;
        int w0 = wr_cnt, r0 = rd_cnt;
        exec_len = 16'd2000;
        clr_mon();
        xfer({8'h02, 8'h01, 16'h1111}, 32, rd);
        exec_len = 16'd7;
        xfer({8'h02, 8'h02, 16'h2222}, 32, rd);
        xfer({8'h03, 8'h01, 16'h0000}, 32, rd);
        wait_ready();
        chk(wr_cnt == w0 + 1, "R7 busy write dropped", wr_cnt, w0 + 1);
        chk(rd_cnt == r0, "R7 busy read dropped", rd_cnt, r0);
        chk(acc_status == 5'h11, "R7 status kept", acc_status, 5'h11);
        chk(low_cnt == 2000, "R7 busy not restarted", low_cnt, 2000);
    endtask

    task automatic t_extra();
        logic [15:0] rd;
        int w0 = wr_cnt;
        exec_len = 16'd4;
        xfer({8'h02, 8'h06, 16'hBEEF}, 40, rd);
        wait_ready();
        chk(wr_cnt == w0 + 1, "R11 extra bits ignored", wr_cnt, w0 + 1);
        chk(model[6] == 16'hBEEF, "R11 data intact", model[6], 16'hBEEF);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_badop();
        t_badaddr();
        t_abort();
        t_busy_zero();
        t_busy_drop();
        t_extra();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule